// File: doc/BRIEF.md
# SPI Daisy-Chain Master Sequencer

This block is an SPI master for a string of identical slaves that share one chip select and one serial clock. The serial output of each slave feeds the serial input of the next. Every slave takes a 16-bit frame made of an instruction byte and a data byte. The whole chain therefore acts as one long shift register of 16 bits per device. The master takes one command per device as a parallel array and moves all of them in one operation, so every slave acts on its command at the same instant, when chip select rises.

A write operation shifts all frames out in a single select window. The frame for the device furthest from the master goes first, and the frame for the device wired to the master goes last. A read operation uses two select windows. The first carries a read command with an 8-bit zero filler for every device. The second shifts zeros through the chain while the answers come back on the input pin. The low byte of each returned frame is collected into a parallel result array, and a one-cycle done strobe marks that the result is valid.

The serial clock is derived from the system clock. A divider input sets the length of each half period.

Top module: `spi_chain_master`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, done is 0 and rd_data is all zero.
- R2: A write (start with rd_mode=0) produces exactly one cs_n-low window containing exactly 16*NUM_DEV rising sck edges.
- R3: In a write, MOSI carries one 16-bit frame per device, MSB first. Device k's frame is cmd_instr[8k+7:8k] followed by cmd_data[8k+7:8k]. Device NUM_DEV-1 is sent first and device 0 last, so each slave holds its own frame when cs_n rises.
- R4: A read (start with rd_mode=1) produces two cs_n-low windows, each with exactly 16*NUM_DEV rising sck edges. In the first window device k's frame is cmd_instr[8k+7:8k] followed by 00h, in the same device order as R3. In the second window MOSI is 0 for every bit, so cmd_data has no effect on a read.
- R5: After a read, rd_data[8k+7:8k] holds the low byte of the k-th frame counted from the end of the second window. The first frame received belongs to device NUM_DEV-1 and the last to device 0.
- R6: SPI mode 0 applies. sck is 0 whenever cs_n is 1. MOSI changes only together with a falling sck edge or a falling cs_n, so it is stable across every rising edge. MISO is sampled on rising edges.
- R7: Each sck high and low phase lasts max(half_div,1) system clock cycles. half_div=0 behaves as 1.
- R8: The time from a cs_n fall to the first rising sck edge is at least one half period. The time from the last falling sck edge to the cs_n rise is also at least one half period.
- R9: cs_n stays high for at least one full sck period between the two read windows, and from the last cs_n rise until done.
- R10: A start pulse while an operation is in progress is ignored. It adds no window and does not change the operation under way.
- R11: done is a single-cycle pulse, once per operation. On a read, rd_data is valid in the done cycle. A write leaves rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin an operation |
| rd_mode | input | 1 | 1 = two-window read, 0 = single-window write |
| half_div | input | DIV_W | sck half period in system clocks (0 treated as 1) |
| cmd_instr | input | 8*NUM_DEV | Instruction byte per device, device k at bits 8k+7:8k |
| cmd_data | input | 8*NUM_DEV | Data byte per device for writes, device k at bits 8k+7:8k |
| miso | input | 1 | Serial data from the last device in the chain |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Shared active-low chip select |
| mosi | output | 1 | Serial data to the first device in the chain |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8*NUM_DEV | Read results, device k at bits 8k+7:8k |

## Verification
The timing properties assume that half_div stays constant from start until done. The stimulus changes it only between operations, drawing a fresh value from 0 to 3 each time. The properties also assume that MISO settles within one half period after a falling sck edge. The bench's behavioural slave chain updates its output on the falling edge, so this holds. The command arrays and rd_mode may change at any time, because they are read only when an operation starts. The bench tests this by changing both together with a stray start pulse in the middle of a transfer.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned BYTE_BITS  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } seq_state_e;

  typedef enum logic [1:0] {
    LD_WRITE,
    LD_RDCMD,
    LD_NOP
  } load_sel_e;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] limit_m1;

  always_comb begin
    limit_m1 = (half_div == '0) ? '0 : half_div - 1'b1;
    tick     = run && (cnt_q == limit_m1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R7: ticks never come back to back when the half period exceeds one clock
  assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (limit_m1 != '0)) |=> !tick)
    else $error("tick spacing shorter than half period");

endmodule

// File: rtl/spi_chain_shifter.sv
module spi_chain_shifter import spi_chain_pkg::*; #(
  parameter int unsigned NUM_DEV = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  load_sel_e                    load_sel,
  input  logic                         shift,
  input  logic                         sample,
  input  logic                         capture,
  input  logic [BYTE_BITS*NUM_DEV-1:0] cmd_instr,
  input  logic [BYTE_BITS*NUM_DEV-1:0] cmd_data,
  input  logic                         miso,
  output logic                         mosi,
  output logic [BYTE_BITS*NUM_DEV-1:0] rd_data
);

  localparam int unsigned TOT_BITS = FRAME_BITS * NUM_DEV;
  localparam int unsigned RES_BITS = BYTE_BITS * NUM_DEV;

  logic [TOT_BITS-1:0] wr_img;
  logic [TOT_BITS-1:0] rdcmd_img;
  logic [RES_BITS-1:0] rx_bytes;
  logic [TOT_BITS-1:0] tx_q, tx_d;
  logic [TOT_BITS-1:0] rx_q, rx_d;
  logic [RES_BITS-1:0] res_q, res_d;

  // Highest slice goes out first, so device NUM_DEV-1 sits at the top.
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign wr_img[FRAME_BITS*g +: FRAME_BITS] =
      {cmd_instr[BYTE_BITS*g +: BYTE_BITS], cmd_data[BYTE_BITS*g +: BYTE_BITS]};
    assign rdcmd_img[FRAME_BITS*g +: FRAME_BITS] =
      {cmd_instr[BYTE_BITS*g +: BYTE_BITS], {BYTE_BITS{1'b0}}};
    assign rx_bytes[BYTE_BITS*g +: BYTE_BITS] =
      rx_q[FRAME_BITS*g +: BYTE_BITS];
  end

  always_comb begin
    tx_d = tx_q;
    if (load) begin
      unique case (load_sel)
        LD_WRITE: tx_d = wr_img;
        LD_RDCMD: tx_d = rdcmd_img;
        default:  tx_d = '0;
      endcase
    end else if (shift) begin
      tx_d = {tx_q[TOT_BITS-2:0], 1'b0};
    end
  end

  always_comb begin
    rx_d = rx_q;
    if (sample) begin
      rx_d = {rx_q[TOT_BITS-2:0], miso};
    end
  end

  always_comb begin
    res_d = res_q;
    if (capture) begin
      res_d = rx_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      res_q <= '0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      res_q <= res_d;
    end
  end

  assign mosi    = tx_q[TOT_BITS-1];
  assign rd_data = res_q;

  // R6: shifting and sampling never happen on the same cycle
  assert_shift_sample_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift && sample))
    else $error("shift and sample coincide");

endmodule

// File: rtl/spi_chain_fsm.sv
module spi_chain_fsm import spi_chain_pkg::*; #(
  parameter int unsigned NUM_DEV = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      rd_mode,
  input  logic      tick,
  output logic      run,
  output logic      sck,
  output logic      cs_n,
  output logic      load,
  output load_sel_e load_sel,
  output logic      shift,
  output logic      sample,
  output logic      capture,
  output logic      done
);

  localparam int unsigned TOT_BITS = FRAME_BITS * NUM_DEV;
  localparam int unsigned CNT_W    = $clog2(TOT_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TOT_BITS - 1);

  seq_state_e       state_q, state_d;
  logic             rd_q, rd_d;
  logic             ph2_q, ph2_d;
  logic             sck_q, sck_d;
  logic             csn_q, csn_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             gap_q, gap_d;
  logic             done_q, done_d;

  always_comb begin
    state_d  = state_q;
    rd_d     = rd_q;
    ph2_d    = ph2_q;
    sck_d    = sck_q;
    csn_d    = csn_q;
    bit_d    = bit_q;
    gap_d    = gap_q;
    done_d   = 1'b0;
    load     = 1'b0;
    load_sel = LD_NOP;
    shift    = 1'b0;
    sample   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          rd_d     = rd_mode;
          ph2_d    = 1'b0;
          load     = 1'b1;
          load_sel = rd_mode ? LD_RDCMD : LD_WRITE;
          csn_d    = 1'b0;
          bit_d    = '0;
          state_d  = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (tick) begin
          sck_d   = 1'b1;
          sample  = 1'b1;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (sck_q) begin
            sck_d = 1'b0;
            if (bit_q == LAST_BIT) begin
              state_d = ST_TRAIL;
            end else begin
              shift = 1'b1;
              bit_d = bit_q + 1'b1;
            end
          end else begin
            sck_d  = 1'b1;
            sample = 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (tick) begin
          csn_d   = 1'b1;
          gap_d   = 1'b0;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (!gap_q) begin
            gap_d = 1'b1;
          end else if (rd_q && !ph2_q) begin
            ph2_d    = 1'b1;
            load     = 1'b1;
            load_sel = LD_NOP;
            csn_d    = 1'b0;
            bit_d    = '0;
            state_d  = ST_LEAD;
          end else begin
            done_d  = 1'b1;
            capture = rd_q;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      ph2_q   <= 1'b0;
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      bit_q   <= '0;
      gap_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      ph2_q   <= ph2_d;
      sck_q   <= sck_d;
      csn_q   <= csn_d;
      bit_q   <= bit_d;
      gap_q   <= gap_d;
      done_q  <= done_d;
    end
  end

  assign run  = (state_q != ST_IDLE);
  assign sck  = sck_q;
  assign cs_n = csn_q;
  assign done = done_q;

  // R6: clock rests low while the chain is deselected
  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csn_q |-> !sck_q)
    else $error("sck high while cs_n high");

  // R11: completion strobe lasts one cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done longer than one cycle");

  // R10: a new window opens only from idle or from the inter-phase gap
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn_q) |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_GAP))
    else $error("select window opened from a busy state");

endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master import spi_chain_pkg::*; #(
  parameter int unsigned NUM_DEV = 3,
  parameter int unsigned DIV_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         rd_mode,
  input  logic [DIV_W-1:0]             half_div,
  input  logic [BYTE_BITS*NUM_DEV-1:0] cmd_instr,
  input  logic [BYTE_BITS*NUM_DEV-1:0] cmd_data,
  input  logic                         miso,
  output logic                         sck,
  output logic                         cs_n,
  output logic                         mosi,
  output logic                         done,
  output logic [BYTE_BITS*NUM_DEV-1:0] rd_data
);

  localparam int unsigned TOT_BITS = FRAME_BITS * NUM_DEV;
  localparam int unsigned EDGE_W   = $clog2(TOT_BITS + 1);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       run_w, tick_w, sck_w, csn_w, mosi_w;
  logic       load_w, shift_w, sample_w, capture_w, done_w;
  load_sel_e  load_sel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run_w),
    .half_div (half_div),
    .tick     (tick_w)
  );

  spi_chain_fsm #(.NUM_DEV(NUM_DEV)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .rd_mode  (rd_mode),
    .tick     (tick_w),
    .run      (run_w),
    .sck      (sck_w),
    .cs_n     (csn_w),
    .load     (load_w),
    .load_sel (load_sel_w),
    .shift    (shift_w),
    .sample   (sample_w),
    .capture  (capture_w),
    .done     (done_w)
  );

  spi_chain_shifter #(.NUM_DEV(NUM_DEV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (load_w),
    .load_sel  (load_sel_w),
    .shift     (shift_w),
    .sample    (sample_w),
    .capture   (capture_w),
    .cmd_instr (cmd_instr),
    .cmd_data  (cmd_data),
    .miso      (miso),
    .mosi      (mosi_w),
    .rd_data   (rd_data)
  );

  assign sck  = sck_w;
  assign cs_n = csn_w;
  assign mosi = mosi_w;
  assign done = done_w;

  // Rising-edge counter per select window, used only by the checks below
  logic              sck_prev_q;
  logic [EDGE_W-1:0] rises_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sck_prev_q <= 1'b0;
      rises_q    <= '0;
    end else begin
      sck_prev_q <= sck_w;
      if (csn_w) begin
        rises_q <= '0;
      end else if (sck_w && !sck_prev_q) begin
        rises_q <= rises_q + 1'b1;
      end
    end
  end

  // R2: every select window carries one full chain of frames
  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(csn_w) |-> (rises_q == EDGE_W'(TOT_BITS)))
    else $error("select window with wrong edge count");

  // R6: data line holds steady across each rising clock edge
  assert_mosi_stable_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sck_w) |-> $stable(mosi_w))
    else $error("mosi moved on a rising edge");

  // R8: the clock never rises in the cycle that opens a window
  assert_lead_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(csn_w) |-> !sck_w)
    else $error("sck high as the window opens");

endmodule

// File: tb/spi_chain_master_test.sv
module spi_chain_master_test;

  localparam int N   = 3;
  localparam int DW  = 8;
  localparam int TOT = 16 * N;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             start;
  logic             rd_mode;
  logic [DW-1:0]    half_div;
  logic [8*N-1:0]   cmd_instr;
  logic [8*N-1:0]   cmd_data;
  logic             miso;
  logic             sck;
  logic             cs_n;
  logic             mosi;
  logic             done;
  logic [8*N-1:0]   rd_data;

  spi_chain_master #(.NUM_DEV(N), .DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
    .half_div(half_div), .cmd_instr(cmd_instr), .cmd_data(cmd_data),
    .miso(miso), .sck(sck), .cs_n(cs_n), .mosi(mosi), .done(done),
    .rd_data(rd_data)
  );

  // Behavioural slave chain: 3'b110 = write, 3'b100 = read, low 5 bits = address
  logic [15:0] dev [N];
  logic [7:0]  smem [N][32];
  logic        miso_q;
  assign miso = miso_q;

  initial begin
    miso_q = 1'b0;
    for (int k = 0; k < N; k++) begin
      dev[k] = '0;
      for (int a = 0; a < 32; a++) smem[k][a] = '0;
    end
  end

  always @(posedge sck) begin
    for (int k = N - 1; k > 0; k--) dev[k] = {dev[k][14:0], dev[k-1][15]};
    dev[0] = {dev[0][14:0], mosi};
  end

  always @(negedge sck or negedge cs_n) miso_q = dev[N-1][15];

  always @(posedge cs_n) begin
    for (int k = 0; k < N; k++) begin
      if (dev[k][15:13] == 3'b110) smem[k][dev[k][12:8]] = dev[k][7:0];
      else if (dev[k][15:13] == 3'b100) dev[k] = {dev[k][15:8], smem[k][dev[k][12:8]]};
    end
  end

  // Pin monitor, sampled on the falling system clock edge
  int cyc = 0;
  logic p_cs = 1'b1, p_sck = 1'b0, p_mosi = 1'b0, p_done = 1'b0;
  int t_csfall, t_csrise, t_last, t_lastfall;
  int frames, edges_now, v_mode, v_period, min_lead, min_trail, min_gap;
  int done_cnt, done_wide, done_gap, hd_now;
  int frame_edges [2];
  logic [TOT-1:0] stream_now;
  logic [TOT-1:0] stream [2];
  logic [8*N-1:0] rd_at_done;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_cs && !cs_n) begin
        if (frames > 0 && (cyc - t_csrise) < min_gap) min_gap = cyc - t_csrise;
        frames++;
        edges_now  = 0;
        stream_now = '0;
        t_csfall   = cyc;
      end
      if (!p_sck && sck) begin
        if (edges_now == 0) begin
          if ((cyc - t_csfall) < min_lead) min_lead = cyc - t_csfall;
        end else if ((cyc - t_last) != hd_now) v_period++;
        edges_now++;
        stream_now = {stream_now[TOT-2:0], mosi};
        t_last = cyc;
      end
      if (p_sck && !sck) begin
        if ((cyc - t_last) != hd_now) v_period++;
        t_last     = cyc;
        t_lastfall = cyc;
      end
      if ((mosi !== p_mosi) && !(p_sck && !sck) && !(p_cs && !cs_n)) v_mode++;
      if (sck && cs_n) v_mode++;
      if (!p_cs && cs_n) begin
        if (frames >= 1 && frames <= 2) begin
          frame_edges[frames-1] = edges_now;
          stream[frames-1]      = stream_now;
        end
        if ((cyc - t_lastfall) < min_trail) min_trail = cyc - t_lastfall;
        t_csrise = cyc;
      end
      if (done) begin
        done_cnt++;
        if (p_done) done_wide++;
        rd_at_done = rd_data;
        done_gap   = cyc - t_csrise;
      end
    end
    p_cs   = cs_n;
    p_sck  = sck;
    p_mosi = mosi;
    p_done = done;
  end

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  bit aborted  = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0]     exp_mem [N][32];
  logic [8*N-1:0] last_rd;

  function automatic logic [TOT-1:0] frame_img(input logic [8*N-1:0] ins,
                                               input logic [8*N-1:0] dat,
                                               input bit rdcmd);
    logic [TOT-1:0] img;
    img = '0;
    for (int k = 0; k < N; k++)
      img[16*k +: 16] = {ins[8*k +: 8], rdcmd ? 8'h00 : dat[8*k +: 8]};
    return img;
  endfunction

  task automatic run_txn(input bit rd, input logic [8*N-1:0] ins,
                         input logic [8*N-1:0] dat, input int hd, input bit poke);
    int w;
    @(negedge clk);
    half_div  = DW'(hd);
    rd_mode   = rd;
    cmd_instr = ins;
    cmd_data  = dat;
    hd_now    = (hd == 0) ? 1 : hd;
    frames = 0; edges_now = 0; v_mode = 0; v_period = 0;
    min_lead = 1000000; min_trail = 1000000; min_gap = 1000000;
    done_cnt = 0; done_wide = 0; done_gap = 0;
    frame_edges[0] = 0; frame_edges[1] = 0;
    stream[0] = '0; stream[1] = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start     = 1'b1;
      rd_mode   = ~rd;
      cmd_instr = ~ins;
      cmd_data  = ~dat;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && w < 20000) begin
      @(negedge clk);
      w++;
    end
    if (done_cnt == 0) begin
      chk(1'b0, "R11 timeout waiting for done", 0, 1);
      aborted = 1'b1;
    end
    repeat (6 * hd_now + 12) @(negedge clk);
  endtask

  task automatic common_checks(input bit rd, input bit poke);
    chk(done_cnt == 1, "R11 done pulses", done_cnt, 1);
    chk(done_wide == 0, "R11 done width", done_wide, 0);
    chk(v_mode == 0, "R6 mode-0 violations", v_mode, 0);
    chk(v_period == 0, "R7 half-period violations", v_period, 0);
    chk(min_lead >= hd_now, "R8 lead time", min_lead, hd_now);
    chk(min_trail >= hd_now, "R8 trail time", min_trail, hd_now);
    chk(done_gap >= 2 * hd_now, "R9 cs high before done", done_gap, 2 * hd_now);
    chk(cs_n === 1'b1 && sck === 1'b0, "R10 idle after operation", {cs_n, sck}, 2'b10);
    if (poke) chk(frames == (rd ? 2 : 1), "R10 stray start ignored", frames, rd ? 2 : 1);
  endtask

  task automatic do_write(input logic [5*N-1:0] addr, input logic [8*N-1:0] dat,
                          input int hd, input bit poke);
    logic [8*N-1:0] ins;
    for (int k = 0; k < N; k++) ins[8*k +: 8] = {3'b110, addr[5*k +: 5]};
    run_txn(1'b0, ins, dat, hd, poke);
    for (int k = 0; k < N; k++) exp_mem[k][addr[5*k +: 5]] = dat[8*k +: 8];
    chk(frames == 1, "R2 write windows", frames, 1);
    chk(frame_edges[0] == TOT, "R2 write edges", frame_edges[0], TOT);
    chk(stream[0] == frame_img(ins, dat, 1'b0), "R3 write bit stream",
        stream[0], frame_img(ins, dat, 1'b0));
    for (int k = 0; k < N; k++)
      chk(smem[k][addr[5*k +: 5]] == dat[8*k +: 8], "R3 slave got its frame",
          smem[k][addr[5*k +: 5]], dat[8*k +: 8]);
    chk(rd_data == last_rd, "R11 write keeps rd_data", rd_data, last_rd);
    common_checks(1'b0, poke);
  endtask

  task automatic do_read(input logic [5*N-1:0] addr, input int hd, input bit poke);
    logic [8*N-1:0] ins;
    logic [8*N-1:0] junk;
    logic [8*N-1:0] expv;
    junk = 24'($urandom);
    for (int k = 0; k < N; k++) begin
      ins[8*k +: 8]  = {3'b100, addr[5*k +: 5]};
      expv[8*k +: 8] = exp_mem[k][addr[5*k +: 5]];
    end
    run_txn(1'b1, ins, junk, hd, poke);
    chk(frames == 2, "R4 read windows", frames, 2);
    chk(frame_edges[0] == TOT, "R4 command window edges", frame_edges[0], TOT);
    chk(frame_edges[1] == TOT, "R4 collect window edges", frame_edges[1], TOT);
    chk(stream[0] == frame_img(ins, junk, 1'b1), "R4 command bit stream",
        stream[0], frame_img(ins, junk, 1'b1));
    chk(stream[1] == '0, "R4 collect stream all zero", stream[1], 0);
    chk(min_gap >= 2 * hd_now, "R9 gap between windows", min_gap, 2 * hd_now);
    for (int k = 0; k < N; k++)
      chk(rd_at_done[8*k +: 8] == expv[8*k +: 8], "R5 read byte per device",
          rd_at_done[8*k +: 8], expv[8*k +: 8]);
    chk(rd_data == expv, "R5 rd_data held after done", rd_data, expv);
    last_rd = rd_data;
    common_checks(1'b1, poke);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd4711);
    for (int k = 0; k < N; k++)
      for (int a = 0; a < 32; a++) exp_mem[k][a] = '0;
    rst_n = 1'b0; start = 1'b0; rd_mode = 1'b0; half_div = '0;
    cmd_instr = '0; cmd_data = '0; last_rd = '0; hd_now = 1;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && done === 1'b0, "R1 pins in reset",
        {cs_n, sck, done}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && done === 1'b0, "R1 pins after reset",
        {cs_n, sck, done}, 3'b100);
    chk(rd_data === '0, "R1 rd_data after reset", rd_data, 0);

    // Directed: distinct values per device, half_div 0 acting as 1 (R7)
    do_write({5'd2, 5'd1, 5'd0}, {8'h1F, 8'hCF, 8'h7E}, 0, 1'b0);
    if (!aborted) do_read({5'd2, 5'd1, 5'd0}, 1, 1'b0);
    // Directed: stray start mid-transfer on both operation kinds (R10)
    if (!aborted) do_write({5'd3, 5'd3, 5'd3}, {8'hA5, 8'h5A, 8'hFF}, 2, 1'b1);
    if (!aborted) do_read({5'd3, 5'd3, 5'd3}, 2, 1'b1);
    // Directed: read of never-written locations returns zero
    if (!aborted) do_read({5'd31, 5'd30, 5'd29}, 3, 1'b0);

    for (int i = 0; i < 24 && !aborted; i++) begin
      logic [5*N-1:0] a;
      logic [8*N-1:0] d;
      for (int k = 0; k < N; k++) a[5*k +: 5] = 5'($urandom_range(0, 3));
      d = 24'($urandom);
      if ($urandom_range(0, 2) != 0) do_write(a, d, $urandom_range(0, 3), 1'b0);
      if (!aborted) begin
        for (int k = 0; k < N; k++) a[5*k +: 5] = 5'($urandom_range(0, 3));
        do_read(a, $urandom_range(0, 3), 1'b0);
      end
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule